// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block sits between a set of peripheral request lines and a small processor core. Each source has a sticky pending flag that is set on a rising edge of its request line, and a per-source enable bit. A global enable gates all of them. When the global enable is on and at least one source is both pending and enabled, the controller picks the source with the lowest index. It then raises a request to the core, together with the entry address of that source in a vector table.

The core answers with an acknowledge. On that acknowledge the controller clears the chosen flag and drops the global enable, so that the handler runs with interrupts masked. Software has four controls. It clears flags by writing ones to a mask, rewrites the enable bits, and turns the global enable on or off. A return strobe from the core turns the global enable back on. A select input moves the vector table from address zero to a configurable boot base. Slot 0 of either table is kept for reset, and each source slot is two words wide.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A rising edge on `req_in[i]` sets `pend[i]` at the next clock edge, whether or not source i is enabled; a held-high line sets the flag only once.
- R2: `irq_req` rises only one clock after a cycle in which `gie` was 1 and some bit of `pend & enable` was 1, and it stays low while no source is enabled.
- R3: When several enabled sources are pending, the one with the lowest index is chosen and reported on `irq_id`.
- R4: `irq_vec` equals base + 2*(id+1), where base is 0 when `use_boot` is 0 and BOOT_BASE when it is 1, sampled in the cycle the request is raised.
- R5: `ack` while `irq_req` is 1 clears the chosen flag, clears `gie` and drops `irq_req` at the next edge; `ack` while `irq_req` is 0 changes nothing.
- R6: With `clr_wr` high, each 1 bit of `clr_mask` clears the matching flag and each 0 bit leaves its flag as it was.
- R7: If a rising edge and a write-one-clear hit the same flag in the same cycle, the flag ends up set.
- R8: `reti` or `gie_set` sets `gie`, and `gie_clr` clears it. `gie_clr` wins over both of them, and an acknowledge that is taken wins over all three.
- R9: From the cycle `irq_req` rises until the acknowledge, `irq_req`, `irq_id` and `irq_vec` do not change, even if flags, enables, `gie` or `use_boot` change.
- R10: After reset all flags, enables, `gie` and `irq_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_in | input | N_SRC | Peripheral request lines, edge sensitive |
| en_wr | input | 1 | Load strobe for the enable bits |
| en_data | input | N_SRC | New enable bits |
| clr_wr | input | 1 | Write-one-to-clear strobe for pending flags |
| clr_mask | input | N_SRC | Flags to clear (1 = clear) |
| gie_set | input | 1 | Set the global enable |
| gie_clr | input | 1 | Clear the global enable |
| reti | input | 1 | Return-from-interrupt strobe, sets the global enable |
| ack | input | 1 | Core acknowledge of the current request |
| use_boot | input | 1 | Vector table at BOOT_BASE when 1, at 0 when 0 |
| irq_req | output | 1 | Interrupt request to the core |
| irq_id | output | $clog2(N_SRC) | Index of the selected source |
| irq_vec | output | ADDR_W | Word address of the selected vector slot |
| pend | output | N_SRC | Pending flags |
| gie | output | 1 | Global interrupt enable |

## Verification
A flag that is lost or set by mistake shows on `pend` one edge after the event. It also shows on `irq_req` and `irq_id` one edge later, once the source is enabled and `gie` is on. A wrong global-enable state shows directly on `gie` and then as a missing or extra request in the next cycle. A selection that drifts while waiting for the acknowledge shows at once as a change of `irq_id` or `irq_vec`. For this reason the outputs are compared every cycle against an independent model, across directed corner cases and a long random run.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int MAX_SRC = 32;

  // Lowest set bit index; 0 if none.
  function automatic int first_set(input logic [MAX_SRC-1:0] v);
    int r;
    r = 0;
    for (int i = MAX_SRC - 1; i >= 0; i--) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction

  // Slot address: table base plus (index + 1) slots; slot 0 is reset.
  function automatic logic [31:0] slot_addr(input logic use_boot,
                                            input logic [31:0] boot_base,
                                            input int idx,
                                            input int slot_words);
    logic [31:0] base;
    base = use_boot ? boot_base : 32'd0;
    return base + 32'(idx + 1) * 32'(slot_words);
  endfunction
endpackage

// File: rtl/vic_flags.sv
module vic_flags #(
  parameter int N_SRC = 8,
  localparam int IDW = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] req_in,
  input  logic             en_wr,
  input  logic [N_SRC-1:0] en_data,
  input  logic             clr_wr,
  input  logic [N_SRC-1:0] clr_mask,
  input  logic             take,
  input  logic [IDW-1:0]   take_id,
  output logic [N_SRC-1:0] flag_o,
  output logic [N_SRC-1:0] en_o
);
  logic [N_SRC-1:0] prev_q, flag_q, en_q;
  logic [N_SRC-1:0] rise, clr_vec, ack_vec, flag_d;

  assign rise    = req_in & ~prev_q;
  assign clr_vec = clr_wr ? clr_mask : '0;

  always_comb begin
    for (int i = 0; i < N_SRC; i++) ack_vec[i] = take && (take_id == IDW'(i));
  end

  // New edge wins over both software clear and acknowledge clear.
  assign flag_d = (flag_q & ~clr_vec & ~ack_vec) | rise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      flag_q <= '0;
      en_q   <= '0;
    end else begin
      prev_q <= req_in;
      flag_q <= flag_d;
      if (en_wr) en_q <= en_data;
    end
  end

  assign flag_o = flag_q;
  assign en_o   = en_q;

  a_r1_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((flag_q & $past(rise)) == $past(rise)));
  a_r7_edge_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && |(clr_mask & rise)) |=>
      ((flag_q & $past(clr_mask & rise)) == $past(clr_mask & rise)));
  a_r6_one_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && |(clr_mask & ~rise)) |=> ((flag_q & $past(clr_mask & ~rise)) == '0));
  a_r6_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !take) |=>
      ((flag_q & $past(flag_q & ~clr_mask)) == $past(flag_q & ~clr_mask)));
  a_r5_ack_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !rise[take_id]) |=> !flag_q[$past(take_id)]);
endmodule

// File: rtl/vic_select.sv
module vic_select
  import vic_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int ADDR_W = 16,
  parameter int SLOT_WORDS = 2,
  parameter logic [ADDR_W-1:0] BOOT_BASE = 16'h3800,
  localparam int IDW = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  flag,
  input  logic [N_SRC-1:0]  en,
  input  logic              gie,
  input  logic              ack,
  input  logic              use_boot,
  output logic              req_o,
  output logic [IDW-1:0]    id_o,
  output logic [ADDR_W-1:0] vec_o,
  output logic              take_o
);
  logic [N_SRC-1:0]   cand;
  logic [MAX_SRC-1:0] cand_w;
  logic               any_cand, raise, take;
  int                 win;
  logic [31:0]        win_vec;
  logic               req_q;
  logic [IDW-1:0]     id_q;
  logic [ADDR_W-1:0]  vec_q;

  assign cand     = flag & en;
  assign any_cand = |cand;

  always_comb begin
    cand_w = '0;
    cand_w[N_SRC-1:0] = cand;
  end

  assign win     = first_set(cand_w);
  assign win_vec = slot_addr(use_boot, 32'(BOOT_BASE), win, SLOT_WORDS);
  assign raise   = !req_q && gie && any_cand;
  assign take    = req_q && ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      id_q  <= '0;
      vec_q <= '0;
    end else if (take) begin
      req_q <= 1'b0;
    end else if (raise) begin
      req_q <= 1'b1;
      id_q  <= IDW'(win);
      vec_q <= win_vec[ADDR_W-1:0];
    end
  end

  assign req_o  = req_q;
  assign id_o   = id_q;
  assign vec_o  = vec_q;
  assign take_o = take;

  a_r2_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q) |-> $past(gie && any_cand));
  a_r3_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q) |-> (($past(cand) & ((N_SRC'(1) << id_q) - N_SRC'(1))) == '0));
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !ack) |=> (req_q && $stable(id_q) && $stable(vec_q)));
  a_r5_req_drops: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !req_q);
endmodule

// File: rtl/vic_gie.sv
module vic_gie (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic gie_set,
  input  logic gie_clr,
  input  logic reti,
  output logic gie_o
);
  logic gie_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                gie_q <= 1'b0;
    else if (take)             gie_q <= 1'b0;
    else if (gie_clr)          gie_q <= 1'b0;
    else if (gie_set || reti)  gie_q <= 1'b1;
  end

  assign gie_o = gie_q;

  a_r5_entry_masks: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !gie_q);
  a_r8_set_or_return: assert property (@(posedge clk) disable iff (!rst_n)
    ((gie_set || reti) && !gie_clr && !take) |=> gie_q);
  a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    gie_clr |=> !gie_q);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int N_SRC = 8,
  parameter int ADDR_W = 16,
  parameter int SLOT_WORDS = 2,
  parameter logic [ADDR_W-1:0] BOOT_BASE = 16'h3800,
  localparam int IDW = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  req_in,
  input  logic              en_wr,
  input  logic [N_SRC-1:0]  en_data,
  input  logic              clr_wr,
  input  logic [N_SRC-1:0]  clr_mask,
  input  logic              gie_set,
  input  logic              gie_clr,
  input  logic              reti,
  input  logic              ack,
  input  logic              use_boot,
  output logic              irq_req,
  output logic [IDW-1:0]    irq_id,
  output logic [ADDR_W-1:0] irq_vec,
  output logic [N_SRC-1:0]  pend,
  output logic              gie
);
  logic [N_SRC-1:0] en_bits;
  logic             take;

  vic_flags #(.N_SRC(N_SRC)) u_flags (
    .clk(clk), .rst_n(rst_n), .req_in(req_in),
    .en_wr(en_wr), .en_data(en_data),
    .clr_wr(clr_wr), .clr_mask(clr_mask),
    .take(take), .take_id(irq_id),
    .flag_o(pend), .en_o(en_bits)
  );

  vic_gie u_gie (
    .clk(clk), .rst_n(rst_n), .take(take),
    .gie_set(gie_set), .gie_clr(gie_clr), .reti(reti), .gie_o(gie)
  );

  vic_select #(.N_SRC(N_SRC), .ADDR_W(ADDR_W), .SLOT_WORDS(SLOT_WORDS),
               .BOOT_BASE(BOOT_BASE)) u_sel (
    .clk(clk), .rst_n(rst_n), .flag(pend), .en(en_bits), .gie(gie),
    .ack(ack), .use_boot(use_boot),
    .req_o(irq_req), .id_o(irq_id), .vec_o(irq_vec), .take_o(take)
  );
endmodule

// File: tb/tb_prio_irq_ctrl.sv
`timescale 1ns/1ps
module tb_prio_irq_ctrl;
  localparam int N = 8;
  localparam int AW = 16;
  localparam logic [AW-1:0] BOOT = 16'h3800;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] req_in = '0, en_data = '0, clr_mask = '0;
  logic en_wr = 0, clr_wr = 0, gie_set = 0, gie_clr = 0, reti = 0, ack = 0, use_boot = 0;
  logic irq_req, gie_o;
  logic [2:0] irq_id;
  logic [AW-1:0] irq_vec;
  logic [N-1:0] pend;

  prio_irq_ctrl #(.N_SRC(N), .ADDR_W(AW), .SLOT_WORDS(2), .BOOT_BASE(BOOT)) dut (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .en_wr(en_wr), .en_data(en_data),
    .clr_wr(clr_wr), .clr_mask(clr_mask), .gie_set(gie_set), .gie_clr(gie_clr),
    .reti(reti), .ack(ack), .use_boot(use_boot),
    .irq_req(irq_req), .irq_id(irq_id), .irq_vec(irq_vec), .pend(pend), .gie(gie_o)
  );

  always #5 clk = ~clk;

  int total = 0, bad = 0;
  bit done = 0;

  // Reference model state
  logic [N-1:0] m_prev, m_flag, m_en;
  logic m_gie, m_req;
  int m_id;
  logic [AW-1:0] m_vec;

  function automatic logic [AW-1:0] exp_vec(input logic boot, input int id);
    return (boot ? BOOT : 16'd0) + AW'(2 * id + 2);
  endfunction

  function automatic int lowest(input logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    logic [N-1:0] rise, clrv, ackv, nflag;
    logic take, ngie;
    rise = req_in & ~m_prev;
    clrv = clr_wr ? clr_mask : '0;
    take = m_req && ack;
    ackv = take ? (N'(1) << m_id) : '0;
    nflag = (m_flag & ~clrv & ~ackv) | rise;
    if (take) ngie = 0;
    else if (gie_clr) ngie = 0;
    else if (gie_set || reti) ngie = 1;
    else ngie = m_gie;
    if (take) m_req = 0;
    else if (!m_req && m_gie && |(m_flag & m_en)) begin
      m_req = 1;
      m_id = lowest(m_flag & m_en);
      m_vec = exp_vec(use_boot, m_id);
    end
    if (en_wr) m_en = en_data;
    m_flag = nflag;
    m_gie = ngie;
    m_prev = req_in;
  endtask

  task automatic cycle();
    model_step();
    @(posedge clk);
    #1;
    chk("R1/R6/R7 pend", 32'(pend), 32'(m_flag));
    chk("R2/R5 irq_req", 32'(irq_req), 32'(m_req));
    chk("R8 gie", 32'(gie_o), 32'(m_gie));
    if (m_req) begin
      chk("R3 irq_id", 32'(irq_id), 32'(m_id));
      chk("R4/R9 irq_vec", 32'(irq_vec), 32'(m_vec));
    end
    en_wr = 0; clr_wr = 0; gie_set = 0; gie_clr = 0; reti = 0; ack = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    m_prev = '0; m_flag = '0; m_en = '0; m_gie = 0; m_req = 0; m_id = 0; m_vec = '0;
    repeat (3) @(posedge clk);
    #1;
    // R10 reset state
    chk("R10 pend", 32'(pend), 0);
    chk("R10 irq_req", 32'(irq_req), 0);
    chk("R10 gie", 32'(gie_o), 0);
    rst_n = 1;

    // R1: edge on disabled source sets flag
    req_in = 8'h20; cycle();
    req_in = 8'h00; cycle();
    chk("R1 disabled source flagged", 32'(pend), 32'h20);
    // R2: gie on but nothing enabled -> no request
    gie_set = 1; cycle(); cycle();
    chk("R2 no enable no req", 32'(irq_req), 0);
    // R3/R4: enable 3 and 5, edge on 3 in same cycle
    en_wr = 1; en_data = 8'h28; req_in = 8'h08; cycle();
    req_in = 8'h00; cycle();
    chk("R3 lowest chosen", 32'(irq_id), 3);
    chk("R4 vector base 0", 32'(irq_vec), 32'h8);
    // R9: hold while use_boot and enables change
    use_boot = 1; en_wr = 1; en_data = 8'h20; cycle(); cycle(); cycle();
    chk("R9 req held", 32'(irq_req), 1);
    chk("R9 vec held", 32'(irq_vec), 32'h8);
    // R5: acknowledge
    ack = 1; cycle();
    chk("R5 req drop", 32'(irq_req), 0);
    chk("R5 gie drop", 32'(gie_o), 0);
    chk("R5 flag cleared", 32'(pend), 32'h20);
    ack = 1; cycle();
    chk("R5 stray ack ignored", 32'(pend), 32'h20);
    // R8 return, then R4 boot vector for source 5
    reti = 1; cycle();
    chk("R8 reti sets gie", 32'(gie_o), 1);
    cycle();
    chk("R4 boot vector", 32'(irq_vec), 32'h380C);
    ack = 1; cycle();
    // R6: w1c
    en_wr = 1; en_data = 8'h00; req_in = 8'h06; cycle();
    req_in = 8'h00; cycle();
    clr_wr = 1; clr_mask = 8'h02; cycle();
    chk("R6 one clears zero keeps", 32'(pend), 32'h04);
    // R7: edge and clear together on bit 2
    req_in = 8'h04; clr_wr = 1; clr_mask = 8'h04; cycle();
    chk("R7 edge beats clear", 32'(pend[2]), 1);
    req_in = 8'h00; cycle();
    // R8 set and clear together
    gie_set = 1; cycle();
    gie_set = 1; gie_clr = 1; cycle();
    chk("R8 clear wins", 32'(gie_o), 0);

    // Random phase
    for (int k = 0; k < 4000; k++) begin
      req_in = N'($urandom);
      use_boot = 1'($urandom);
      en_wr = ($urandom % 8) == 0; en_data = N'($urandom);
      clr_wr = ($urandom % 6) == 0; clr_mask = N'($urandom);
      gie_set = ($urandom % 6) == 0;
      gie_clr = ($urandom % 10) == 0;
      reti = ($urandom % 8) == 0;
      ack = ($urandom % 3) == 0;
      cycle();
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule